// File: doc/BRIEF.md
# Glitch-free reference clock switch

The block drives one master clock from either of two asynchronous reference clocks, an internal one and an external one, and changes between them without producing a runt pulse. Each source has its own gate lane. A lane closes its gate only while its own clock is low. It opens its gate only after a synchronizer in its own domain has seen the other lane's gate closed, so the two gates are never open together and the master clock stays low for the whole handover.

The wanted source comes from a stored configuration bit when `use_stored` is high. When `use_stored` is low it comes from the live pin `sel_int`. A rising edge on `sel_int` in live mode also closes the external gate at once, without waiting for an external clock edge. This lets the move to the internal clock finish when the external input has stopped at either level. `ext_active` shows whether the external gate is open.

Top module: `refclk_switch`

## Requirements
- R1: While `rst_n` is low and after it is released, the internal source is selected: `mclk` runs at the internal rate and `ext_active` is 0. This holds when the stored bit asks for internal.
- R2: With `use_stored`=1, `stored_ext`=1 selects the external clock on `mclk` and `stored_ext`=0 selects the internal clock.
- R3: The internal and external gates are never open at the same time. Each gate changes state only while its own clock is low.
- R4: With `use_stored`=0, `sel_int`=0 selects the external clock and `sel_int`=1 selects the internal clock.
- R5: In live mode, a rising edge of `sel_int` completes the move to the internal clock even when the external clock is stopped low or stopped high.
- R6: During any handover `mclk` is held low. `mclk` never has a high or low phase shorter than the shorter half-period of the two sources.
- R7: `ext_active` is 1 exactly while the external gate is open and 0 otherwise.
- R8: With `use_stored`=1, edges on `sel_int` have no effect on the selected source.
- R9: A handover completes within SYNC_STAGES+2 periods of the outgoing clock plus SYNC_STAGES+2 periods of the incoming clock after the request changes. This assumes both clocks run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_int_clk | input | 1 | Internal reference clock |
| ref_ext_clk | input | 1 | External reference clock, may stop |
| rst_n | input | 1 | Asynchronous active-low reset |
| use_stored | input | 1 | 1: stored bit chooses source; 0: `sel_int` chooses |
| stored_ext | input | 1 | Stored choice, 1 = external |
| sel_int | input | 1 | Live select, 1 = internal; rising edge forces internal |
| mclk | output | 1 | Master clock |
| ext_active | output | 1 | 1 while the external source drives `mclk` |

## Verification
The assertions assume three things about the inputs:
- The request does not toggle again before the previous handover has completed.
- `use_stored` and `stored_ext` change only when the source they select is already the active one.
- In live mode, `sel_int` rises while the external clock is low or stopped, since a forced close during an external high phase would shorten that phase.

The stimulus waits out every handover before the next request. It changes the mode only after setting the pin to match the active source. It raises `sel_int` just after a falling external edge, or after stopping the external clock.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  typedef enum logic {SRC_INT = 1'b0, SRC_EXT = 1'b1} src_t;
  localparam int DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/refclk_sync.sv
module refclk_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  localparam int TOP = STAGES - 1;
  logic [TOP:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n)
        if (!arst_n) chain <= RST_VAL;
        else         chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n)
        if (!arst_n) chain <= {STAGES{RST_VAL}};
        else         chain <= {chain[TOP-1:0], d};
    end
  endgenerate

  assign q = chain[TOP];
endmodule

// File: rtl/refclk_lane.sv
module refclk_lane #(
  parameter int STAGES = 2,
  parameter bit RST_ON = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic want,
  input  logic other_en,
  output logic en,
  output logic gclk
);
  logic open_req;
  logic open_q;

  assign open_req = want & ~other_en;

  refclk_sync #(.STAGES(STAGES), .RST_VAL(RST_ON)) u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .d      (open_req),
    .q      (open_q)
  );

  always_ff @(negedge clk or negedge arst_n)
    if (!arst_n) en <= RST_ON;
    else         en <= open_q;

  assign gclk = clk & en;

  always @(en) begin
    AST_GATE_WHEN_LOW: assert (!arst_n || !clk)
      else $error("gate moved while its clock was high"); // R3
  end
endmodule

// File: rtl/refclk_switch.sv
module refclk_switch
  import refclk_pkg::*;
#(
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic ref_int_clk,
  input  logic ref_ext_clk,
  input  logic rst_n,
  input  logic use_stored,
  input  logic stored_ext,
  input  logic sel_int,
  output logic mclk,
  output logic ext_active
);
  src_t want_src;
  logic int_en, ext_en;
  logic int_gclk, ext_gclk;
  logic force_q;
  logic force_clr_n;
  logic ext_arst_n;

  always_comb begin
    if (use_stored) want_src = stored_ext ? SRC_EXT : SRC_INT;
    else            want_src = sel_int ? SRC_INT : SRC_EXT;
  end

  // Edge-triggered escape from the external source; cleared once internal gate opens.
  assign force_clr_n = rst_n & ~int_en;
  always_ff @(posedge sel_int or negedge force_clr_n)
    if (!force_clr_n) force_q <= 1'b0;
    else              force_q <= ~use_stored;

  assign ext_arst_n = rst_n & ~force_q;

  refclk_lane #(.STAGES(SYNC_STAGES), .RST_ON(1'b1)) u_int_lane (
    .clk      (ref_int_clk),
    .arst_n   (rst_n),
    .want     (want_src == SRC_INT),
    .other_en (ext_en),
    .en       (int_en),
    .gclk     (int_gclk)
  );

  refclk_lane #(.STAGES(SYNC_STAGES), .RST_ON(1'b0)) u_ext_lane (
    .clk      (ref_ext_clk),
    .arst_n   (ext_arst_n),
    .want     (want_src == SRC_EXT),
    .other_en (int_en),
    .en       (ext_en),
    .gclk     (ext_gclk)
  );

  assign mclk       = int_gclk | ext_gclk;
  assign ext_active = ext_en;

  AST_ONE_SOURCE: assert property (@(posedge ref_int_clk) disable iff (!rst_n)
    !(int_en && ext_en)) else $error("both gates open"); // R3
  AST_EXT_OPENS_AFTER_INT: assert property (@(posedge ref_ext_clk) disable iff (!rst_n)
    $rose(ext_en) |-> !int_en) else $error("external opened early"); // R3
  AST_RESET_INTERNAL: assert property (@(posedge ref_int_clk)
    $rose(rst_n) |-> (int_en && !ext_en)) else $error("reset state wrong"); // R1
  AST_FORCE_CLOSES_EXT: assert property (@(posedge ref_int_clk) disable iff (!rst_n)
    ($rose(sel_int) && !use_stored && $past(!use_stored)) |=> !ext_en)
    else $error("select edge left external open"); // R5
endmodule

// File: tb/refclk_switch_bench.sv
`timescale 1ns/1ps
module refclk_switch_bench;
  logic ref_int_clk = 1'b0;
  logic ref_ext_clk = 1'b0;
  logic ext_run = 1'b1;
  logic rst_n = 1'b0;
  logic use_stored = 1'b1;
  logic stored_ext = 1'b0;
  logic sel_int = 1'b1;
  logic mclk, ext_active;

  int checks = 0;
  int errors = 0;
  int rises = 0;
  int runts = 0;
  bit done = 0;
  realtime last_edge = 0;

  refclk_switch u_refclk_switch (
    .ref_int_clk (ref_int_clk),
    .ref_ext_clk (ref_ext_clk),
    .rst_n       (rst_n),
    .use_stored  (use_stored),
    .stored_ext  (stored_ext),
    .sel_int     (sel_int),
    .mclk        (mclk),
    .ext_active  (ext_active)
  );

  always #2 ref_int_clk = ~ref_int_clk;          // 250 MHz
  always begin
    #3;
    if (ext_run) ref_ext_clk = ~ref_ext_clk;     // ~166 MHz, can stop at a level
  end

  always @(posedge mclk) rises++;
  always @(mclk) begin
    if (rst_n && ($realtime - last_edge) < 1.9) runts++;
    last_edge = $realtime;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rate(input string req, input int exp);
    int start, n;
    start = rises;
    #120;
    n = rises - start;
    checks++;
    if (n < exp - 1 || n > exp + 1) begin
      errors++;
      $display("FAIL %s actual %0d edges expected %0d", req, n, exp);
    end
  endtask

  task automatic t_reset();
    #10;
    chk("R1 ext_active in reset", ext_active, 0);
    rst_n = 1'b1;
    #30;
    chk("R1 ext_active after reset", ext_active, 0);
    chk_rate("R1 internal rate after reset", 30);
  endtask

  task automatic t_stored();
    stored_ext = 1'b1;
    #50;
    chk("R2 R9 stored external selected", ext_active, 1);
    chk_rate("R2 external rate", 20);
    for (int i = 0; i < 3; i++) begin
      @(negedge ref_ext_clk); #0.5 sel_int = ~sel_int;
      #20;
    end
    chk("R8 sel ignored in stored mode", ext_active, 1);
    chk_rate("R8 rate unchanged by sel", 20);
    sel_int = 1'b1;
    stored_ext = 1'b0;
    #50;
    chk("R2 R9 stored internal selected", ext_active, 0);
    chk_rate("R2 internal rate", 30);
    chk("R3 R6 no runt so far", runts, 0);
  endtask

  task automatic t_live();
    use_stored = 1'b0;
    #20;
    chk("R4 live high keeps internal", ext_active, 0);
    sel_int = 1'b0;
    #50;
    chk("R4 R7 live low selects external", ext_active, 1);
    chk_rate("R4 external rate live", 20);
    @(negedge ref_ext_clk); #0.5 sel_int = 1'b1;
    #50;
    chk("R4 R9 live rise selects internal", ext_active, 0);
    chk_rate("R4 internal rate live", 30);
    chk("R6 no runt in live handovers", runts, 0);
  endtask

  task automatic t_stuck(input bit level);
    sel_int = 1'b0;
    #50;
    chk("R5 external active before stop", ext_active, 1);
    if (level) @(posedge ref_ext_clk); else @(negedge ref_ext_clk);
    ext_run = 1'b0;
    #10;
    chk("R5 mclk follows stopped level", mclk, level);
    sel_int = 1'b1;
    #5;
    chk("R5 R7 external gate closed at once", ext_active, 0);
    #40;
    chk_rate(level ? "R5 internal after stuck high" : "R5 internal after stuck low", 30);
    chk("R6 no runt after stuck source", runts, 0);
    ext_run = 1'b1;
    #20;
  endtask

  initial begin
    t_reset();
    t_stored();
    t_live();
    t_stuck(1'b0);
    t_stuck(1'b1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule